// File: doc/BRIEF.md
# ECC Write-Poisoning and Error-Status Unit

This unit sits in one channel of a memory controller, between the write and read data paths and a small memory that stores each word with single-error-correct, double-error-detect check bits. Software can arm a deliberate fault through a control register. The fault is either a correctable one-bit flip or an uncorrectable two-bit flip. The next accepted write on the channel consumes the armed request. That write stores its word with the chosen data bits inverted after the check bits have been computed. Because the check bits no longer match the data, the decoder sees the fault when that location is read back.

The fault is reported only on read-back. A corrected word raises a sticky correctable flag and returns the fixed data with a normal response. An uncorrectable word raises a sticky uncorrectable flag and returns an error response. A lock register guards the other registers against writes. Memory traffic and arming are refused until the init-done input is high. A controller with two channels instantiates the unit once per channel, and each copy has its own registers.

Top module: `ecc_poison_unit`

## Requirements
- R1: After reset, the lock register (address 0) reads 1 in bit 0, and the status register (address 1) and the control register (address 2) read 0. `rsp_valid` is low.
- R2: Bit 0 of the lock register can always be written. While it is 1, writes to addresses 1 and 2 have no effect, but all registers can still be read.
- R3: `wr_ready` and `rd_ready` are high only while `init_done` is high. A write to the control register while `init_done` is low leaves it unchanged.
- R4: A read accepted in one cycle returns `rsp_valid` high in the next cycle. For an unpoisoned word, the response carries the written data with `rsp_err` = 0 (OKAY).
- R5: Writing 1 to bit 3 of the control register arms a one-bit fault. Read-back of the next written word returns the original data with `rsp_err` = 0, and sets bit 3 of the status register.
- R6: Writing 1 to bit 4 of the control register arms a two-bit fault. Read-back of the next written word returns `rsp_err` = 1 (SLVERR) and sets bit 4 of the status register.
- R7: A poisoned write by itself changes no status bit. Status bits rise only from a read response.
- R8: Both armed bits clear in the cycle a write is accepted. If bits 3 and 4 are both armed, the two-bit fault is applied.
- R9: Status bits stay set until software writes 1 to the same bit position at address 1.
- R10: Only the first write after arming is poisoned. Later writes are stored clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_done | input | 1 | Memory initialization complete |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register address: 0 lock, 1 status, 2 control |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data for `reg_addr` (combinational) |
| wr_valid | input | 1 | Write command valid |
| wr_ready | output | 1 | Write command accepted |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| rd_valid | input | 1 | Read command valid |
| rd_ready | output | 1 | Read command accepted |
| rd_addr | input | ADDR_W | Read word address |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | DATA_W | Read data, corrected when possible |
| rsp_err | output | 1 | Response status: 0 OKAY, 1 SLVERR |

## Verification
The properties assume the following about the inputs:
- Software does not write the control register in the same cycle that a write command is accepted. The self-clear check excludes that cycle.
- Status and control bits change only through the register port or the data paths.

The directed stimulus meets these conditions in the following ways:
- Inputs are driven on the falling edge.
- Every register access is completed before any memory command is issued.
- Reads go only to addresses written earlier, so no uninitialized word reaches the decoder.

// File: rtl/ecc_poison_pkg.sv
package ecc_poison_pkg;
   localparam int unsigned ADR_LOCK = 0;
   localparam int unsigned ADR_STAT = 1;
   localparam int unsigned ADR_CTRL = 2;
   localparam int unsigned BIT_ONE  = 3;
   localparam int unsigned BIT_TWO  = 4;

   typedef enum logic {RSP_OKAY = 1'b0, RSP_SLVERR = 1'b1} rsp_e;

   // number of Hamming check bits for a data width
   function automatic int unsigned chk_bits(input int unsigned dw);
      int unsigned p;
      p = 1;
      while ((1 << p) < dw + p + 1) p++;
      return p;
   endfunction

   // codeword position of data bit idx: idx-th non power of two from 3
   function automatic int unsigned data_pos(input int unsigned idx);
      int unsigned pos;
      int unsigned cnt;
      pos = 0;
      cnt = 0;
      for (int unsigned k = 3; k < 1024; k++) begin
         if (pos == 0 && (k & (k - 1)) != 0) begin
            if (cnt == idx) pos = k;
            cnt++;
         end
      end
      return pos;
   endfunction
endpackage

// File: rtl/ecc_chk_gen.sv
module ecc_chk_gen #(
   parameter int unsigned DW = 32,
   localparam int unsigned CB = ecc_poison_pkg::chk_bits(DW)
) (
   input  logic [DW-1:0] data,
   output logic [CB-1:0] chk
);
   function automatic logic [DW-1:0] col_mask(input int unsigned j);
      logic [DW-1:0] m;
      int unsigned   p;
      for (int unsigned i = 0; i < DW; i++) begin
         p    = ecc_poison_pkg::data_pos(i);
         m[i] = ((p >> j) & 1) != 0;
      end
      return m;
   endfunction

   for (genvar j = 0; j < CB; j++) begin : g_chk
      localparam logic [DW-1:0] MASK = col_mask(j);
      assign chk[j] = ^(data & MASK);
   end
endmodule

// File: rtl/ecc_secded_dec.sv
module ecc_secded_dec #(
   parameter int unsigned DW = 32,
   localparam int unsigned CB = ecc_poison_pkg::chk_bits(DW),
   localparam int unsigned CW = DW + CB + 1
) (
   input  logic [CW-1:0] code,
   output logic [DW-1:0] data_out,
   output logic          one_err,
   output logic          two_err
);
   logic [CB-1:0] chk_calc;
   logic [CB-1:0] syn;
   logic [DW-1:0] corr;
   logic          par;

   ecc_chk_gen #(.DW(DW)) u_gen (.data(code[DW-1:0]), .chk(chk_calc));

   assign syn = chk_calc ^ code[DW+CB-1:DW];
   assign par = ^code;

   for (genvar i = 0; i < DW; i++) begin : g_fix
      localparam int unsigned POS = ecc_poison_pkg::data_pos(i);
      assign corr[i] = par && (syn == CB'(POS));
   end

   assign data_out = code[DW-1:0] ^ corr;
   assign one_err  = par;
   assign two_err  = !par && (syn != '0);
endmodule

// File: rtl/ecc_poison_regs.sv
module ecc_poison_regs #(
   parameter int unsigned RW        = 8,
   parameter int unsigned AW        = 2,
   parameter bit          LOCK_INIT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init_done,
   input  logic          reg_wr,
   input  logic [AW-1:0] reg_addr,
   input  logic [RW-1:0] reg_wdata,
   output logic [RW-1:0] reg_rdata,
   input  logic          wr_fire,
   input  logic          seen_one,
   input  logic          seen_two,
   output logic          lock_q,
   output logic          arm_one,
   output logic          arm_two,
   output logic          stat_one,
   output logic          stat_two
);
   import ecc_poison_pkg::*;

   logic wr_ok;
   logic hit_stat;
   logic hit_ctrl;

   assign wr_ok    = reg_wr && !lock_q;
   assign hit_stat = wr_ok && (reg_addr == AW'(ADR_STAT));
   assign hit_ctrl = wr_ok && (reg_addr == AW'(ADR_CTRL)) && init_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q   <= LOCK_INIT;
         arm_one  <= 1'b0;
         arm_two  <= 1'b0;
         stat_one <= 1'b0;
         stat_two <= 1'b0;
      end else begin
         if (reg_wr && reg_addr == AW'(ADR_LOCK)) lock_q <= reg_wdata[0];
         if (hit_ctrl) begin
            arm_one <= reg_wdata[BIT_ONE];
            arm_two <= reg_wdata[BIT_TWO];
         end else if (wr_fire) begin
            arm_one <= 1'b0;
            arm_two <= 1'b0;
         end
         stat_one <= (stat_one && !(hit_stat && reg_wdata[BIT_ONE])) || seen_one;
         stat_two <= (stat_two && !(hit_stat && reg_wdata[BIT_TWO])) || seen_two;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         AW'(ADR_LOCK): reg_rdata[0] = lock_q;
         AW'(ADR_STAT): begin
            reg_rdata[BIT_ONE] = stat_one;
            reg_rdata[BIT_TWO] = stat_two;
         end
         AW'(ADR_CTRL): begin
            reg_rdata[BIT_ONE] = arm_one;
            reg_rdata[BIT_TWO] = arm_two;
         end
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/ecc_poison_unit.sv
module ecc_poison_unit #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned REG_W     = 8,
   parameter int unsigned REG_AW    = 2,
   parameter int unsigned ONE_BIT   = 0,
   parameter int unsigned TWO_BIT_A = 0,
   parameter int unsigned TWO_BIT_B = 1,
   parameter bit          LOCK_INIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_done,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_valid,
   output logic              rd_ready,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_err
);
   import ecc_poison_pkg::*;

   localparam int unsigned CB    = chk_bits(DATA_W);
   localparam int unsigned CW    = DATA_W + CB + 1;
   localparam int unsigned DEPTH = 1 << ADDR_W;

   if (DATA_W < 4) begin : g_bad_dw
      $error("DATA_W must be at least 4");
   end
   if (ONE_BIT >= DATA_W || TWO_BIT_A >= DATA_W || TWO_BIT_B >= DATA_W) begin : g_bad_bit
      $error("fault bit positions must lie inside the data word");
   end
   if (TWO_BIT_A == TWO_BIT_B) begin : g_bad_pair
      $error("two-bit fault needs distinct positions");
   end
   if (REG_W <= BIT_TWO || REG_AW < 2) begin : g_bad_reg
      $error("register port too narrow");
   end

   logic              wr_fire, rd_fire;
   logic              lock_q, arm_one, arm_two, stat_one, stat_two;
   logic [CB-1:0]     enc_chk;
   logic [CW-1:0]     enc_word, flip, code_q;
   logic [CW-1:0]     mem [DEPTH];
   logic              dec_one, dec_two;
   logic [DATA_W-1:0] dec_data;

   assign wr_ready = init_done;
   assign rd_ready = init_done;
   assign wr_fire  = wr_valid && wr_ready;
   assign rd_fire  = rd_valid && rd_ready;

   ecc_poison_regs #(.RW(REG_W), .AW(REG_AW), .LOCK_INIT(LOCK_INIT)) u_regs (
      .clk(clk), .rst_n(rst_n), .init_done(init_done),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .wr_fire(wr_fire),
      .seen_one(rsp_valid && dec_one), .seen_two(rsp_valid && dec_two),
      .lock_q(lock_q), .arm_one(arm_one), .arm_two(arm_two),
      .stat_one(stat_one), .stat_two(stat_two)
   );

   ecc_chk_gen #(.DW(DATA_W)) u_enc (.data(wr_data), .chk(enc_chk));
   assign enc_word = {^{enc_chk, wr_data}, enc_chk, wr_data};

   always_comb begin
      flip = '0;
      if (arm_two) begin
         flip[TWO_BIT_A] = 1'b1;
         flip[TWO_BIT_B] = 1'b1;
      end else if (arm_one) begin
         flip[ONE_BIT] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_fire) mem[wr_addr] <= enc_word ^ flip;
      if (rd_fire) code_q <= mem[rd_addr];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rsp_valid <= 1'b0;
      else        rsp_valid <= rd_fire;
   end

   ecc_secded_dec #(.DW(DATA_W)) u_dec (
      .code(code_q), .data_out(dec_data), .one_err(dec_one), .two_err(dec_two)
   );

   assign rsp_data = dec_data;
   assign rsp_err  = rsp_valid && dec_two ? RSP_SLVERR : RSP_OKAY;
endmodule

// File: rtl/ecc_poison_chk.sv
module ecc_poison_chk #(
   parameter int unsigned AW = 2,
   parameter int unsigned RW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          init_done,
   input logic          reg_wr,
   input logic [AW-1:0] reg_addr,
   input logic [RW-1:0] reg_wdata,
   input logic          wr_valid,
   input logic          wr_ready,
   input logic          rd_valid,
   input logic          rd_ready,
   input logic          rsp_valid,
   input logic          rsp_err,
   input logic          lock_q,
   input logic          arm_one,
   input logic          arm_two,
   input logic          stat_one,
   input logic          stat_two
);
   import ecc_poison_pkg::*;

   logic ctrl_wr, stat_clr1;
   assign ctrl_wr   = reg_wr && reg_addr == AW'(ADR_CTRL);
   assign stat_clr1 = reg_wr && !lock_q && reg_addr == AW'(ADR_STAT) && reg_wdata[BIT_ONE];

   p_lock_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q && ctrl_wr && !(wr_valid && wr_ready) |=> $stable({arm_one, arm_two}));

   p_no_arm_early_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done && !arm_one && !arm_two |=> !arm_one && !arm_two);

   p_rsp_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && rd_ready |=> rsp_valid);

   p_slverr_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_err |=> stat_two);

   p_quiet_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid && !stat_one |=> !stat_one);

   p_self_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && wr_ready && !ctrl_wr |=> !arm_one && !arm_two);

   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stat_one && !stat_clr1 |=> stat_one);
endmodule

bind ecc_poison_unit ecc_poison_chk #(.AW(REG_AW), .RW(REG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .init_done(init_done),
   .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_ready(rd_ready),
   .rsp_valid(rsp_valid), .rsp_err(rsp_err), .lock_q(lock_q),
   .arm_one(arm_one), .arm_two(arm_two), .stat_one(stat_one), .stat_two(stat_two)
);

// File: tb/ecc_poison_unit_test.sv
module ecc_poison_unit_test;
   localparam int unsigned DW = 32;
   localparam int unsigned AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          init_done = 1'b0;
   logic          reg_wr = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic [7:0]    reg_wdata = '0;
   logic [7:0]    reg_rdata;
   logic          wr_valid = 1'b0;
   logic          wr_ready;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_valid = 1'b0;
   logic          rd_ready;
   logic [AW-1:0] rd_addr = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_data;
   logic          rsp_err;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   ecc_poison_unit uut (
      .clk(clk), .rst_n(rst_n), .init_done(init_done),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic mem_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic mem_read(input logic [AW-1:0] a, output logic v,
                           output logic [DW-1:0] d, output logic e);
      @(negedge clk);
      rd_valid = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_valid = 1'b0;
      v = rsp_valid; d = rsp_data; e = rsp_err;
   endtask

   task automatic t_reset_and_init;
      logic [7:0] r;
      reg_read(2'd0, r); check(32'(r), 32'h01, "R1 lock after reset");
      reg_read(2'd1, r); check(32'(r), 32'h00, "R1 status after reset");
      reg_read(2'd2, r); check(32'(r), 32'h00, "R1 control after reset");
      check(32'(rsp_valid), 32'd0, "R1 rsp_valid after reset");
      check(32'(wr_ready), 32'd0, "R3 wr_ready before init");
      check(32'(rd_ready), 32'd0, "R3 rd_ready before init");
      reg_write(2'd0, 8'h00);
      reg_write(2'd2, 8'h08);
      reg_read(2'd2, r); check(32'(r), 32'h00, "R3 arm ignored before init");
      init_done = 1'b1;
      #1 check(32'(wr_ready), 32'd1, "R3 wr_ready after init");
   endtask

   task automatic t_lock;
      logic [7:0] r;
      reg_write(2'd0, 8'h01);
      reg_read(2'd0, r); check(32'(r), 32'h01, "R2 lock reads 1");
      reg_write(2'd2, 8'h18);
      reg_read(2'd2, r); check(32'(r), 32'h00, "R2 control write ignored while locked");
      reg_write(2'd0, 8'h00);
      reg_read(2'd0, r); check(32'(r), 32'h00, "R2 unlock");
   endtask

   task automatic t_clean;
      logic v, e; logic [DW-1:0] d;
      mem_write(4'd1, 32'h1234_5678);
      mem_read(4'd1, v, d, e);
      check(32'(v), 32'd1, "R4 rsp_valid one cycle after read");
      check(d, 32'h1234_5678, "R4 clean data");
      check(32'(e), 32'd0, "R4 OKAY response");
   endtask

   task automatic t_single;
      logic v, e; logic [DW-1:0] d; logic [7:0] r;
      reg_write(2'd2, 8'h08);
      reg_read(2'd2, r); check(32'(r), 32'h08, "R5 one-bit armed");
      mem_write(4'd3, 32'hA5A5_0F0F);
      reg_read(2'd2, r); check(32'(r), 32'h00, "R8 arm cleared by write");
      reg_read(2'd1, r); check(32'(r), 32'h00, "R7 no flag at write");
      mem_read(4'd3, v, d, e);
      check(d, 32'hA5A5_0F0F, "R5 corrected data");
      check(32'(e), 32'd0, "R5 OKAY on one-bit");
      reg_read(2'd1, r); check(32'(r), 32'h08, "R5 status bit 3");
      mem_read(4'd1, v, d, e);
      reg_read(2'd1, r); check(32'(r), 32'h08, "R9 bit stays set");
      reg_write(2'd1, 8'h08);
      reg_read(2'd1, r); check(32'(r), 32'h00, "R9 write-one clears");
   endtask

   task automatic t_double;
      logic v, e; logic [DW-1:0] d; logic [7:0] r;
      reg_write(2'd2, 8'h10);
      mem_write(4'd5, 32'hDEAD_BEEF);
      reg_read(2'd1, r); check(32'(r), 32'h00, "R7 no flag at two-bit write");
      mem_read(4'd5, v, d, e);
      check(32'(e), 32'd1, "R6 SLVERR on two-bit");
      reg_read(2'd1, r); check(32'(r), 32'h10, "R6 status bit 4");
      reg_write(2'd1, 8'h10);
      reg_read(2'd1, r); check(32'(r), 32'h00, "R9 clear bit 4");
   endtask

   task automatic t_both;
      logic v, e; logic [DW-1:0] d; logic [7:0] r;
      reg_write(2'd2, 8'h18);
      mem_write(4'd6, 32'h0F0F_F0F0);
      reg_read(2'd2, r); check(32'(r), 32'h00, "R8 both arms cleared");
      mem_read(4'd6, v, d, e);
      check(32'(e), 32'd1, "R8 two-bit wins when both armed");
      reg_read(2'd1, r); check(32'(r), 32'h10, "R8 only bit 4 flagged");
      reg_write(2'd1, 8'h18);
   endtask

   task automatic t_only_next;
      logic v, e; logic [DW-1:0] d; logic [7:0] r;
      reg_write(2'd2, 8'h08);
      mem_write(4'd7, 32'h1111_2222);
      mem_write(4'd8, 32'h3333_4444);
      mem_read(4'd8, v, d, e);
      check(d, 32'h3333_4444, "R10 later write clean data");
      reg_read(2'd1, r); check(32'(r), 32'h00, "R10 later write no flag");
      mem_read(4'd7, v, d, e);
      check(d, 32'h1111_2222, "R10 first write corrected");
      reg_read(2'd1, r); check(32'(r), 32'h08, "R10 first write flagged");
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_and_init;
      t_lock;
      t_clean;
      t_single;
      t_double;
      t_both;
      t_only_next;
      repeat (2) @(negedge clk);
      finish_run;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run;
   end
endmodule